// File: doc/BRIEF.md
# Core Voltage Target Sequencer

This block turns a supply voltage request, given in millivolts, into a 5-bit regulator target code. The code goes into three regulator target fields of a 32-bit control word in one write. The block then holds a busy flag until the regulator has had time to settle. The settle time is counted in microsecond ticks from an external timebase.

A request is a one-cycle strobe with the millivolt value and the current control word. The control word supplies the bits that are not target fields, and its lowest field supplies the code now in force. The block clamps the value into the legal range and divides it by the step size with a small repeating subtractor.

Raising the code costs a wait for each step. Lowering it costs nothing, and repeating the current code does nothing at all. The first request after reset always takes a fixed long wait, because the three rails may not yet agree. When the operation ends, the block pulses done and reports the voltage the chosen code produces.

Top module: `vdd_target_seq`

## Requirements
- R1: A request below 725 mV selects code 0; 725 mV selects code 1.
- R2: A request above 1450 mV selects code 31 (all ones); 1450 mV itself selects code 30.
- R3: For requests from 725 to 1450 mV the code is (mV - 700) / 25, rounded down.
- R4: A write places the code in bits [4:0], [13:9] and [22:18] of the word. All other bits are taken from reg_word_i as it was on the request cycle. reg_we_o pulses for exactly one cycle per write.
- R5: act_mv_o equals code * 25 + 700 for the code in force. It reads 700 out of reset.
- R6: The first request after reset always writes, even if the code is unchanged. It then waits 84 tick pulses before done.
- R7: After the first request, a code equal to bits [4:0] of reg_word_i gives no write and no wait. reg_word_o is unchanged and done follows.
- R8: After the first request, a higher code writes and then waits 3 tick pulses per code step of increase before done.
- R9: After the first request, a lower code writes and finishes in the same cycle as the write, with no tick counted.
- R10: busy_o is high from the cycle after an accepted request until done_o pulses for one cycle. A request strobe while busy is ignored.
- R11: Out of reset busy_o, done_o and reg_we_o are low and reg_word_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one cycle |
| req_mv_i | input | 12 | Requested voltage in mV |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| reg_word_i | input | 32 | Current control word, sampled with the request |
| reg_word_o | output | 32 | Control word held by the block |
| reg_we_o | output | 1 | Write strobe for reg_word_o |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at the end of an operation |
| act_mv_o | output | 12 | Voltage of the code in force, in mV |

## Verification
The bench uses the default parameters: a 12-bit millivolt input, a 5-bit code, 3 ticks per step and a 28-step first wait. With these values both clamp edges and the largest upward step of 93 ticks are reachable, as is the full first-settle wait. Ticks arrive at random, so wait counting is tested against gaps of uneven length. Requests stray into busy periods, and reset is applied a second time so that the first-request rule is exercised twice.

// File: rtl/vdd_target_seq.sv
module vdd_target_seq #(
  parameter int MV_W        = 12,
  parameter int CODE_W      = 5,
  parameter int REG_W       = 32,
  parameter int MV_MIN      = 725,
  parameter int MV_MAX      = 1450,
  parameter int MV_BASE     = 700,
  parameter int MV_STEP     = 25,
  parameter int US_PER_STEP = 3,
  parameter int FIRST_STEPS = 28,
  parameter int F0_LSB      = 0,
  parameter int F1_LSB      = 9,
  parameter int F2_LSB      = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [MV_W-1:0]   req_mv_i,
  input  logic              us_tick_i,
  input  logic [REG_W-1:0]  reg_word_i,
  output logic [REG_W-1:0]  reg_word_o,
  output logic              reg_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [MV_W-1:0]   act_mv_o
);

  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int MAX_WAIT = ((FIRST_STEPS > CODE_MAX) ? FIRST_STEPS : CODE_MAX) * US_PER_STEP;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_APPLY, S_WAIT} state_t;

  state_t             state_q;
  logic [MV_W-1:0]    rem_q;
  logic [CODE_W-1:0]  quot_q, old_q;
  logic [REG_W-1:0]   cap_word_q, word_q, word_n;
  logic [WAIT_W-1:0]  cnt_q, wait_n;
  logic [MV_W-1:0]    act_q;
  logic               first_q, we_q, done_q, write_n;

  assign busy_o     = (state_q != S_IDLE);
  assign reg_word_o = word_q;
  assign reg_we_o   = we_q;
  assign done_o     = done_q;
  assign act_mv_o   = act_q;

  assign write_n = !first_q || (quot_q != old_q);

  always_comb begin
    if (!first_q)
      wait_n = WAIT_W'(FIRST_STEPS * US_PER_STEP);
    else if (quot_q > old_q)
      wait_n = WAIT_W'(US_PER_STEP * int'(quot_q - old_q));
    else
      wait_n = '0;
  end

  always_comb begin
    word_n = cap_word_q;
    word_n[F0_LSB +: CODE_W] = quot_q;
    word_n[F1_LSB +: CODE_W] = quot_q;
    word_n[F2_LSB +: CODE_W] = quot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      rem_q      <= '0;
      quot_q     <= '0;
      old_q      <= '0;
      cap_word_q <= '0;
      word_q     <= '0;
      cnt_q      <= '0;
      act_q      <= MV_W'(MV_BASE);
      first_q    <= 1'b0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (req_i) begin
          cap_word_q <= reg_word_i;
          old_q      <= reg_word_i[F0_LSB +: CODE_W];
          quot_q     <= '0;
          if (req_mv_i < MV_W'(MV_MIN)) begin
            state_q <= S_APPLY;
          end else if (req_mv_i > MV_W'(MV_MAX)) begin
            quot_q  <= {CODE_W{1'b1}};
            state_q <= S_APPLY;
          end else begin
            rem_q   <= req_mv_i - MV_W'(MV_BASE);
            state_q <= S_DIV;
          end
        end
        S_DIV: begin
          if (rem_q >= MV_W'(MV_STEP)) begin
            rem_q  <= rem_q - MV_W'(MV_STEP);
            quot_q <= quot_q + 1'b1;
          end else begin
            state_q <= S_APPLY;
          end
        end
        S_APPLY: begin
          first_q <= 1'b1;
          if (write_n) begin
            word_q <= word_n;
            we_q   <= 1'b1;
            act_q  <= MV_W'(int'(quot_q) * MV_STEP + MV_BASE);
          end
          if (wait_n == '0) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q   <= wait_n;
            state_q <= S_WAIT;
          end
        end
        S_WAIT: if (us_tick_i) begin
          if (cnt_q == WAIT_W'(1)) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_fields_agree_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (reg_word_o[F0_LSB +: CODE_W] == reg_word_o[F1_LSB +: CODE_W]) &&
                 (reg_word_o[F0_LSB +: CODE_W] == reg_word_o[F2_LSB +: CODE_W]));

  assert_act_matches_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> act_mv_o == MV_W'(int'(reg_word_o[F0_LSB +: CODE_W]) * MV_STEP + MV_BASE));

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_busy_ignores_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i) |=> $stable(cap_word_q));

  assert_wait_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && !us_tick_i) |=> $stable(cnt_q) && busy_o);

  assert_lower_no_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_APPLY && first_q && quot_q < old_q) |=> done_o && reg_we_o);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/vdd_target_seq_tb_top.sv
module vdd_target_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FM = 32'h1F | (32'h1F << 9) | (32'h1F << 18);

  logic clk = 0, rst_n = 0, req_i = 0, us_tick_i = 0;
  logic [11:0] req_mv_i = '0, act_mv_o;
  logic [31:0] reg_word_i = '0, reg_word_o;
  logic reg_we_o, busy_o, done_o;

  int n_vec = 0, n_bad = 0;
  bit first_m;
  int cur_code;
  logic [31:0] model_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdd_target_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_mv_i(req_mv_i),
    .us_tick_i(us_tick_i), .reg_word_i(reg_word_i), .reg_word_o(reg_word_o),
    .reg_we_o(reg_we_o), .busy_o(busy_o), .done_o(done_o), .act_mv_o(act_mv_o));

  function automatic int exp_code(input int mv);
    if (mv < 725) return 0;
    if (mv > 1450) return 31;
    return (mv - 700) / 25;
  endfunction

  function automatic logic [31:0] place(input int c);
    logic [31:0] f = 32'(c) & 32'h1F;
    return f | (f << 9) | (f << 18);
  endfunction

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", r, act, act, exp, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; req_i = 0; us_tick_i = 0;
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && reg_we_o == 0, "R11 idle flags", {busy_o, done_o, reg_we_o}, 0);
    chk(reg_word_o == 0, "R11 word", reg_word_o, 0);
    chk(act_mv_o == 700, "R5 reset act", act_mv_o, 700);
    rst_n = 1;
    first_m = 1; cur_code = 0; model_word = '0;
    @(negedge clk);
  endtask

  task automatic run_req(input int mv, input bit stray);
    int code, w, ticks, cyc, we_cnt;
    bit wr, armed;
    logic [31:0] others, exp_w, got_w;
    string rt;
    code = exp_code(mv);
    wr = first_m || (code != cur_code);
    w = first_m ? 84 : (code > cur_code ? 3 * (code - cur_code) : 0);
    rt = (mv < 725) ? "R1" : (mv > 1450) ? "R2" : "R3";
    others = $urandom;
    exp_w = wr ? ((others & ~FM) | place(code)) : model_word;
    ticks = 0; cyc = 0; we_cnt = 0; armed = 0; got_w = '0;
    @(negedge clk);
    req_i = 1; req_mv_i = 12'(mv); reg_word_i = (others & ~FM) | place(cur_code); us_tick_i = 0;
    @(negedge clk);
    req_i = 0;
    chk(busy_o == 1, "R10 busy after request", busy_o, 1);
    forever begin
      if (armed && us_tick_i) ticks++;
      if (reg_we_o) begin we_cnt++; armed = 1; got_w = reg_word_o; end
      if (done_o) break;
      us_tick_i = 1'($urandom % 2);
      if (stray && cyc == 2) begin
        req_i = 1; req_mv_i = 12'($urandom % 2000); reg_word_i = $urandom;
      end else req_i = 0;
      cyc++;
      if (cyc > 3000) begin chk(0, "R10 done never seen", cyc, 0); break; end
      @(negedge clk);
    end
    req_i = 0; us_tick_i = 0;
    chk(we_cnt == (wr ? 1 : 0), wr ? "R4 one write strobe" : "R7 no write on equal code", we_cnt, wr ? 1 : 0);
    if (wr) chk(got_w == exp_w, {rt, " R4 written word"}, got_w, exp_w);
    chk(ticks == w, first_m ? "R6 first settle ticks" : (code > cur_code ? "R8 upward ticks" :
        (code < cur_code ? "R9 downward ticks" : "R7 equal ticks")), ticks, w);
    chk(act_mv_o == 12'(code * 25 + 700), {rt, " R5 actual mV"}, act_mv_o, code * 25 + 700);
    @(negedge clk);
    chk(done_o == 0 && busy_o == 0, "R10 done single pulse, idle", {done_o, busy_o}, 0);
    chk(reg_word_o == exp_w, "R4 R7 word held", reg_word_o, exp_w);
    cur_code = code; first_m = 0; model_word = exp_w;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    run_req(700, 0);
    run_req(724, 0);
    run_req(725, 1);
    run_req(1450, 0);
    run_req(1451, 1);
    run_req(4095, 0);
    run_req(0, 0);
    run_req(1000, 1);
    run_req(999, 0);
    run_req(1449, 0);
    for (int i = 0; i < 200; i++)
      run_req(int'($urandom % 2000), 1'($urandom % 3 == 0));
    do_reset();
    run_req(1200, 0);
    run_req(1200, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule